// File: doc/BRIEF.md
# I2C Controller Interrupt Status Unit

This unit keeps the event flags of an I2C master controller and reduces them to one interrupt line. Bus-engine and FIFO logic deliver each event as a single-cycle pulse. The unit latches each pulse into a sticky flag. Software clears a flag by writing a one to it. A per-event enable mask decides which flags can raise the interrupt.

Software reaches the unit through a small register port with 16-bit words. The port has a word address, a write strobe and a combinational read path. The unit offers two views of the flags:
- The unfiltered view also shows the live bus-busy level.
- The filtered view shows the flags ANDed with the enable mask. Writes to this view clear flags.

Software changes the mask through two write addresses, one that sets bits and one that clears them. Both addresses read back the current mask.

The unit also runs the soft-reset handshake. A soft-reset request wipes the flags, the mask and the control word. After that, the reset-done bit reads 1 only once software has set the module-enable bit again. A power-on reset leaves the unit in the same state as a soft reset.

Top module: `i2c_irq_status`

## Requirements
- R1: After `rst_n` is released, every register reads 0 (control, reset-done, both flag views, mask), apart from the bus-busy bit, and `irq` is 0.
- R2: A pulse on `evt_i[k]` sets flag k on that clock edge, and the flag stays set until cleared. The flag positions are: bit 0 no-acknowledge, bit 1 arbitration lost, bit 2 access ready, bit 3 receive ready, bit 4 receive draining, bit 5 transmit ready, bit 6 transmit draining.
- R3: A write to address 3 (filtered view) clears every flag whose data bit is 1, whatever the mask. Flags whose data bit is 0 keep their value.
- R4: When an event pulse and a clearing write hit the same flag in the same cycle, the flag stays set.
- R5: Address 2 reads the raw flags in bits 6:0 and the `bus_busy` level in bit 12. Address 3 reads raw flags AND mask, and its bit 12 is always 0.
- R6: A write to address 4 sets the mask bits where the data is 1. A write to address 5 clears the mask bits where the data is 1. Reading either address returns the mask.
- R7: `irq` is 1 in the cycle after any filtered flag is 1, and 0 in the cycle after none is.
- R8: Writes to address 2 have no effect on any flag.
- R9: Writing 1 to bit 0 of address 1 (soft reset) clears all flags, the mask and the control word, and sets reset-done to 0. The soft reset wins over an event pulse in the same cycle.
- R10: Reset-done (address 1, bit 0) becomes 1 one cycle after control bit 15 (enable) reads 1 following a reset. It stays 1 until the next reset, even if enable is cleared later.
- R11: Address 0 is a 16-bit control word that reads back the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 7 | Single-cycle event pulses, one per flag |
| bus_busy | input | 1 | Live bus-busy level, shown in the raw view |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational on address) |
| irq | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach is a collision in a single clock edge: an event pulse arriving together with a clearing write to the same flag, or together with a soft reset. In each case the two must resolve in opposite directions. The bench drives both inputs in the same low clock phase, so they are sampled on one edge, and then reads the flag back through the raw view. It also sweeps all 128 mask values against flag patterns computed from the mask index, and checks the filtered view and the interrupt in the cycle after each setup.

// File: rtl/i2cisu_pkg.sv
package i2cisu_pkg;
  localparam int REG_W    = 16;
  localparam int EVT_N    = 7;
  localparam int ADDR_W   = 3;
  localparam int BUSY_POS = 12;
  localparam int EN_POS   = 15;
  localparam int SRST_POS = 0;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 3'd0,
    A_SRST = 3'd1,
    A_RAW  = 3'd2,
    A_STAT = 3'd3,
    A_MSET = 3'd4,
    A_MCLR = 3'd5
  } reg_addr_e;

  typedef struct packed {
    logic ctrl;
    logic srst;
    logic stat;
    logic mset;
    logic mclr;
  } wr_strb_t;
endpackage

// File: rtl/isu_regdec.sv
module isu_regdec
  import i2cisu_pkg::*;
#(
  parameter int RW   = REG_W,
  parameter int AW   = ADDR_W,
  parameter int NEVT = EVT_N
) (
  input  logic            reg_wr,
  input  logic [AW-1:0]   reg_addr,
  input  logic            srst_bit,
  input  logic [RW-1:0]   ctrl_q,
  input  logic            done_q,
  input  logic [NEVT-1:0] flags_q,
  input  logic [NEVT-1:0] mask_q,
  input  logic            bus_busy,
  output wr_strb_t        strb,
  output logic [RW-1:0]   rdata
);
  localparam int PAD = RW - NEVT;

  always_comb begin
    strb      = '0;
    strb.ctrl = reg_wr && (reg_addr == A_CTRL);
    strb.srst = reg_wr && (reg_addr == A_SRST) && srst_bit;
    strb.stat = reg_wr && (reg_addr == A_STAT);
    strb.mset = reg_wr && (reg_addr == A_MSET);
    strb.mclr = reg_wr && (reg_addr == A_MCLR);
  end

  always_comb begin
    rdata = '0;
    case (reg_addr)
      A_CTRL: rdata = ctrl_q;
      A_SRST: rdata[SRST_POS] = done_q;
      A_RAW: begin
        rdata = {{PAD{1'b0}}, flags_q};
        rdata[BUSY_POS] = bus_busy;
      end
      A_STAT: rdata = {{PAD{1'b0}}, flags_q & mask_q};
      A_MSET, A_MCLR: rdata = {{PAD{1'b0}}, mask_q};
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/isu_flags.sv
module isu_flags #(
  parameter int NEVT = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wipe,
  input  logic [NEVT-1:0] evt,
  input  logic            clr_we,
  input  logic [NEVT-1:0] clr_bits,
  output logic [NEVT-1:0] flags_q
);
  logic [NEVT-1:0] flags_d;

  for (genvar k = 0; k < NEVT; k++) begin : g_bit
    always_comb begin
      flags_d[k] = flags_q[k];
      if (wipe) flags_d[k] = 1'b0;
      else if (evt[k]) flags_d[k] = 1'b1;
      else if (clr_we && clr_bits[k]) flags_d[k] = 1'b0;
    end

    p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (evt[k] && !wipe) |=> flags_q[k]);
    p_evt_beats_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (evt[k] && clr_we && clr_bits[k] && !wipe) |=> flags_q[k]);
    p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && clr_bits[k] && !evt[k]) |=> !flags_q[k]);
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!wipe && !evt[k] && !(clr_we && clr_bits[k])) |=> $stable(flags_q[k]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  p_wipe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wipe |=> (flags_q == '0));
endmodule

// File: rtl/isu_mask.sv
module isu_mask #(
  parameter int NEVT = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wipe,
  input  logic            set_we,
  input  logic            clr_we,
  input  logic [NEVT-1:0] wbits,
  output logic [NEVT-1:0] mask_q
);
  logic [NEVT-1:0] mask_d;
  logic            mask_en;

  assign mask_en = wipe || set_we || clr_we;

  always_comb begin
    mask_d = mask_q;
    if (wipe)        mask_d = '0;
    else if (set_we) mask_d = mask_q | wbits;
    else if (clr_we) mask_d = mask_q & ~wbits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  p_mask_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we && !wipe) |=> ((mask_q & $past(wbits)) == $past(wbits)));
  p_mask_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !set_we && !wipe) |=> ((mask_q & $past(wbits)) == '0));
  p_mask_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mask_en) |=> $stable(mask_q));
endmodule

// File: rtl/isu_rstseq.sv
module isu_rstseq (
  input  logic clk,
  input  logic rst_n,
  input  logic wipe,
  input  logic en_q,
  output logic done_q
);
  logic pend_q, pend_d, done_d;

  always_comb begin
    pend_d = pend_q;
    done_d = done_q;
    if (wipe) begin
      pend_d = 1'b1;
      done_d = 1'b0;
    end else if (pend_q && en_q) begin
      pend_d = 1'b0;
      done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b1;
      done_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      done_q <= done_d;
    end
  end

  p_done_needs_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(en_q));
  p_done_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wipe |=> !done_q);
  p_done_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !wipe) |=> done_q);
endmodule

// File: rtl/i2c_irq_status.sv
module i2c_irq_status
  import i2cisu_pkg::*;
#(
  parameter int RW   = REG_W,
  parameter int NEVT = EVT_N,
  parameter int AW   = ADDR_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NEVT-1:0] evt_i,
  input  logic            bus_busy,
  input  logic            reg_wr,
  input  logic [AW-1:0]   reg_addr,
  input  logic [RW-1:0]   reg_wdata,
  output logic [RW-1:0]   reg_rdata,
  output logic            irq
);
  wr_strb_t        strb;
  logic [RW-1:0]   ctrl_q, ctrl_d;
  logic            ctrl_en;
  logic [NEVT-1:0] flags_q, mask_q;
  logic            done_q;
  logic            irq_d;

  isu_regdec #(.RW(RW), .AW(AW), .NEVT(NEVT)) u_dec (
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .srst_bit (reg_wdata[SRST_POS]),
    .ctrl_q   (ctrl_q),
    .done_q   (done_q),
    .flags_q  (flags_q),
    .mask_q   (mask_q),
    .bus_busy (bus_busy),
    .strb     (strb),
    .rdata    (reg_rdata)
  );

  isu_flags #(.NEVT(NEVT)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .wipe     (strb.srst),
    .evt      (evt_i),
    .clr_we   (strb.stat),
    .clr_bits (reg_wdata[NEVT-1:0]),
    .flags_q  (flags_q)
  );

  isu_mask #(.NEVT(NEVT)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .wipe   (strb.srst),
    .set_we (strb.mset),
    .clr_we (strb.mclr),
    .wbits  (reg_wdata[NEVT-1:0]),
    .mask_q (mask_q)
  );

  isu_rstseq u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .wipe   (strb.srst),
    .en_q   (ctrl_q[EN_POS]),
    .done_q (done_q)
  );

  assign ctrl_en = strb.ctrl || strb.srst;

  always_comb begin
    ctrl_d = ctrl_q;
    if (strb.srst)      ctrl_d = '0;
    else if (strb.ctrl) ctrl_d = reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  assign irq_d = |(flags_q & mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_d;
  end

  p_irq_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags_q & mask_q) != '0) |=> irq);
  p_irq_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags_q & mask_q) == '0) |=> !irq);
  p_srst_wipes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    strb.srst |=> (ctrl_q == '0 && mask_q == '0));
  p_raw_nowrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_RAW && evt_i == '0) |=> $stable(flags_q));
endmodule

// File: tb/sim_i2c_irq_status.sv
`timescale 1ns/1ps
module sim_i2c_irq_status;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  evt_i = '0;
  logic        bus_busy = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  i2c_irq_status u0 (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .bus_busy(bus_busy),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    reg_addr = a;
    #0.5;
    v = reg_rdata;
  endtask

  task automatic pulse(input logic [6:0] e);
    evt_i = e;
    step();
    evt_i = '0;
  endtask

  initial begin
    logic [15:0] v;
    logic [6:0] f, m, mexp;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(a[2:0], v);
      chk($sformatf("R1 addr%0d", a), v, 16'h0000);
    end
    chk("R1 irq", {15'b0, irq}, 16'h0000);

    // R5 busy bit only in raw view
    bus_busy = 1'b1;
    rd(3'd2, v); chk("R5 busy raw", v, 16'h1000);
    rd(3'd3, v); chk("R5 busy masked", v, 16'h0000);
    bus_busy = 1'b0;

    // R11 control readback
    wr(3'd0, 16'h25C3);
    rd(3'd0, v); chk("R11 ctrl", v, 16'h25C3);
    wr(3'd0, 16'h0000);

    // R2 / R3 per event
    for (int k = 0; k < 7; k++) begin
      pulse(7'(1 << k));
      rd(3'd2, v); chk($sformatf("R2 set bit%0d", k), v, 16'(1 << k));
      step();
      rd(3'd2, v); chk($sformatf("R2 held bit%0d", k), v, 16'(1 << k));
      wr(3'd3, 16'(~(1 << k)) & 16'h007F);
      rd(3'd2, v); chk($sformatf("R3 zero keeps bit%0d", k), v, 16'(1 << k));
      wr(3'd3, 16'(1 << k));
      rd(3'd2, v); chk($sformatf("R3 clear bit%0d", k), v, 16'h0000);
    end

    // R4 collision: event and clear on the same edge
    pulse(7'h41);
    evt_i = 7'h01;
    reg_addr = 3'd3; reg_wdata = 16'h0041; reg_wr = 1'b1;
    step();
    reg_wr = 1'b0; evt_i = '0;
    rd(3'd2, v); chk("R4 event beats clear", v, 16'h0001);

    // R8 raw writes ignored
    wr(3'd2, 16'hFFFF);
    rd(3'd2, v); chk("R8 raw write ignored", v, 16'h0001);
    wr(3'd3, 16'h007F);

    // R5 / R6 / R7 sweep over all masks
    for (int mi = 0; mi < 128; mi++) begin
      m = mi[6:0];
      f = 7'((mi * 37 + 5) & 127);
      wr(3'd3, 16'h007F);
      wr(3'd5, 16'hFFFF);
      pulse(f);
      wr(3'd4, {9'b0, m});
      rd(3'd4, v); chk($sformatf("R6 set m=%0d", mi), v, {9'b0, m});
      rd(3'd5, v); chk($sformatf("R6 read clr m=%0d", mi), v, {9'b0, m});
      rd(3'd3, v); chk($sformatf("R5 masked m=%0d", mi), v, {9'b0, f & m});
      step();
      chk($sformatf("R7 irq m=%0d", mi), {15'b0, irq}, {15'b0, |(f & m)});
      wr(3'd5, 16'h0055);
      mexp = m & 7'h2A;
      rd(3'd5, v); chk($sformatf("R6 clear m=%0d", mi), v, {9'b0, mexp});
      step();
      chk($sformatf("R7 irq after clr m=%0d", mi), {15'b0, irq}, {15'b0, |(f & mexp)});
    end

    // R9 soft reset wipes everything, wins over a same-cycle event
    wr(3'd0, 16'h8000);
    step();
    rd(3'd1, v); chk("R10 done after first enable", v, 16'h0001);
    pulse(7'h7F);
    wr(3'd4, 16'h007F);
    evt_i = 7'h12;
    reg_addr = 3'd1; reg_wdata = 16'h0001; reg_wr = 1'b1;
    step();
    reg_wr = 1'b0; evt_i = '0;
    rd(3'd2, v); chk("R9 flags wiped", v, 16'h0000);
    rd(3'd4, v); chk("R9 mask wiped", v, 16'h0000);
    rd(3'd0, v); chk("R9 ctrl wiped", v, 16'h0000);
    rd(3'd1, v); chk("R9 done wiped", v, 16'h0000);
    step();
    chk("R9 irq low", {15'b0, irq}, 16'h0000);

    // R10 handshake
    wr(3'd0, 16'h0123);
    step();
    rd(3'd1, v); chk("R10 no done without enable", v, 16'h0000);
    wr(3'd0, 16'h8000);
    rd(3'd1, v); chk("R10 done not yet", v, 16'h0000);
    step();
    rd(3'd1, v); chk("R10 done set", v, 16'h0001);
    wr(3'd0, 16'h0000);
    step();
    rd(3'd1, v); chk("R10 done sticky", v, 16'h0001);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule